// File: doc/BRIEF.md
# Prescaled Tick Timer

This block is a single programmable timer that sits behind a plain 32-bit register bus. A prescaler divides the input clock into ticks, and a 28-bit counter counts those ticks up to a programmed target. When the target is reached, the timer sets a pending flag. In repeat mode it then starts again from zero. In one-shot mode it stops and clears its own run bit. The interrupt line is the pending flag gated by an enable bit.

Software drives the timer in a fixed sequence:

1. Stop the timer by writing zero to the control register.
2. Acknowledge any stale pending flag.
3. Program the target.
4. Zero the live count.
5. Write the control word with the run bit, the mode and the divisor.

The live count can be read at any moment while the timer runs.

Top module: `tick_timer`

## Requirements
- R1: Registers are selected by the word address: 0 = target, 1 = live count, 2 = control, 3 = interrupt. When `rd_en` is high, `rdata` shows the selected register combinationally, and it is zero otherwise. Register bits that have no field read as zero. After reset every register reads zero and `irq` is low.
- R2: In the control register, bit 28 is the run bit, bit 24 is the mode (1 = repeat, 0 = one-shot) and bits DIV_W-1:0 are the divisor. While the run bit is zero the live count does not change, so writing zero to control stops the timer.
- R3: While running, the count advances once every d clock cycles, where d is the divisor, and divisor values 0 and 1 act as 2. The first advance lands on the d-th rising edge after the edge that captured the control write.
- R4: A write to the live-count register loads the count, and this takes precedence over a tick in the same cycle. Reading the count never disturbs counting.
- R5: On the tick that brings the count to the target, the pending flag (interrupt register bit 16) is set at that same edge.
- R6: In repeat mode the count returns to zero on the matching tick and counting continues, so matches recur every target × d cycles.
- R7: In one-shot mode the count holds at the target after the match, and the run bit clears itself at that edge.
- R8: Writing 1 to interrupt bit 16 clears the pending flag. Writing 0 there leaves the flag unchanged.
- R9: When a match and a clearing write fall in the same cycle, the pending flag stays set.
- R10: Interrupt bit 20 is the interrupt enable and is written by any interrupt-register write. `irq` is high exactly when the pending flag and the enable are both set.
- R11: Target and count are CNT_W = 28 bits wide. Write-data bits above bit 27 are dropped and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with a 4-bit divisor field and keeps the 28-bit counter. This makes every divisor value from 0 to 15, including the two values that fall back to 2, reachable in a single sweep. For each divisor it drives targets 1 to 4 and checks the exact edge of the first and the second match, along with the count read just before the match. Short periods also make the coincidence of a match with an acknowledge write, and the one-shot stop, cheap to place on an exact cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam logic [1:0] REG_TARGET = 2'd0;
    localparam logic [1:0] REG_COUNT  = 2'd1;
    localparam logic [1:0] REG_CTRL   = 2'd2;
    localparam logic [1:0] REG_INT    = 2'd3;

    localparam int RUN_BIT  = 28;
    localparam int MODE_BIT = 24;
    localparam int PEND_BIT = 16;
    localparam int IE_BIT   = 20;

    typedef enum logic {
        MODE_ONCE   = 1'b0,
        MODE_REPEAT = 1'b1
    } run_mode_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [DIV_W-1:0] div_eff;

    always_comb begin
        div_eff = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
        tick_o  = run_i && (pre_q.phase >= div_eff - 1'b1);
        pre_d   = pre_q;
        if (!run_i || tick_o) begin
            pre_d.phase = '0;
        end else begin
            pre_d.phase = pre_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic             repeat_i,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [CNT_W-1:0] incr;

    always_comb begin
        incr    = cnt_q.count + 1'b1;
        match_o = tick_i && (incr == target_i);
        cnt_d   = cnt_q;
        if (load_i) begin
            cnt_d.count = load_val_i;
        end else if (match_o) begin
            cnt_d.count = repeat_i ? '0 : incr;
        end else if (tick_i) begin
            cnt_d.count = incr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q.count;
endmodule

// File: rtl/tick_irq.sv
module tick_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie_wr_i,
    input  logic ie_val_i,
    output logic pend_o,
    output logic ie_o,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
        logic ie;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (set_i)      irq_d.pend = 1'b1;
        else if (clr_i) irq_d.pend = 1'b0;
        if (ie_wr_i)    irq_d.ie   = ie_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign pend_o = irq_q.pend;
    assign ie_o   = irq_q.ie;
    assign irq_o  = irq_q.pend & irq_q.ie;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 28,
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    typedef struct packed {
        logic [CNT_W-1:0] target;
        logic             run;
        run_mode_e        mode;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_target, wr_count, wr_ctrl, wr_int;
    logic tick, match, pend, ie;
    logic [CNT_W-1:0] count;
    logic unused_wdata;

    assign unused_wdata = ^wdata;
    assign wr_target = wr_en && (addr == REG_TARGET);
    assign wr_count  = wr_en && (addr == REG_COUNT);
    assign wr_ctrl   = wr_en && (addr == REG_CTRL);
    assign wr_int    = wr_en && (addr == REG_INT);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_target) cfg_d.target = wdata[CNT_W-1:0];
        if (wr_ctrl) begin
            cfg_d.run  = wdata[RUN_BIT];
            cfg_d.mode = run_mode_e'(wdata[MODE_BIT]);
            cfg_d.div  = wdata[DIV_W-1:0];
        end else if (match && (cfg_q.mode == MODE_ONCE)) begin
            cfg_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    tick_prescaler #(.DIV_W(DIV_W)) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (cfg_q.run),
        .div_i  (cfg_q.div),
        .tick_o (tick)
    );

    tick_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (wr_count),
        .load_val_i (wdata[CNT_W-1:0]),
        .target_i   (cfg_q.target),
        .repeat_i   (cfg_q.mode == MODE_REPEAT),
        .count_o    (count),
        .match_o    (match)
    );

    tick_irq i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (match),
        .clr_i    (wr_int && wdata[PEND_BIT]),
        .ie_wr_i  (wr_int),
        .ie_val_i (wdata[IE_BIT]),
        .pend_o   (pend),
        .ie_o     (ie),
        .irq_o    (irq)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                REG_TARGET: rdata = 32'(cfg_q.target);
                REG_COUNT:  rdata = 32'(count);
                REG_CTRL: begin
                    rdata[RUN_BIT]     = cfg_q.run;
                    rdata[MODE_BIT]    = cfg_q.mode;
                    rdata[DIV_W-1:0]   = cfg_q.div;
                end
                default: begin
                    rdata[PEND_BIT] = pend;
                    rdata[IE_BIT]   = ie;
                end
            endcase
        end
    end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [31:0]      wdata,
    input logic             tick,
    input logic             match,
    input logic             run_q,
    input logic             mode_q,
    input logic             pend_q,
    input logic [CNT_W-1:0] count_q,
    input logic             irq
);
    logic wr_cnt, wr_ctl, wr_irq;
    assign wr_cnt = wr_en && (addr == REG_COUNT);
    assign wr_ctl = wr_en && (addr == REG_CTRL);
    assign wr_irq = wr_en && (addr == REG_INT);

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_halted_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_cnt) |=> $stable(count_q));

    assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !match) |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));

    assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> pend_q);

    assert_repeat_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode_q && !wr_cnt) |=> (count_q == '0));

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !mode_q && !wr_ctl) |=> !run_q);

    assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_irq && wdata[PEND_BIT] && !match) |=> !pend_q);

    assert_mask_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_irq && !wdata[IE_BIT]) |=> !irq);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .tick    (tick),
    .match   (match),
    .run_q   (cfg_q.run),
    .mode_q  (cfg_q.mode),
    .pend_q  (pend),
    .count_q (count),
    .irq     (irq)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
    localparam int DIV_W = 4;
    localparam logic [31:0] PEND = 32'h0001_0000;
    localparam logic [31:0] IE   = 32'h0010_0000;
    localparam logic [31:0] RUN  = 32'h1000_0000;
    localparam logic [31:0] RPT  = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tick_timer #(.DIV_W(DIV_W)) i_tick_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int eff(input int d);
        return (d < 2) ? 2 : d;
    endfunction

    task automatic start(input int d, input int t, input logic rep);
        wr(2'd2, 32'h0);
        wr(2'd3, PEND | IE);
        wr(2'd0, 32'(t));
        wr(2'd1, 32'h0);
        wr(2'd2, RUN | (rep ? RPT : 32'h0) | 32'(d));
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, w;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset", v, 32'h0);
        end
        check("R1 irq reset", {31'h0, irq}, 32'h0);
        rd(2'd0, v);
        check("R1 rdata gated", rdata, 32'h0);

        // R11 width masking
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v);
        check("R11 target width", v, 32'h0FFF_FFFF);
        wr(2'd1, 32'h1234_5678);
        rd(2'd1, v);
        check("R11 R4 count load", v, 32'h0234_5678);

        // R2 control fields and stop
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v);
        check("R2 ctrl readback", v, RUN | RPT | 32'h0000_000F);
        wr(2'd2, 32'h0);
        rd(2'd1, v);
        cycles(40);
        rd(2'd1, w);
        check("R2 stopped count", w, v);

        // R3 R4 R5 R6 R10 sweep over divisors and targets
        for (int d = 0; d < 16; d++) begin
            for (int t = 1; t <= 4; t++) begin
                int per;
                per = t * eff(d);
                start(d, t, 1'b1);
                cycles(per - 1);
                rd(2'd3, v);
                check($sformatf("R5 no early pend d=%0d t=%0d", d, t), v & PEND, 32'h0);
                rd(2'd1, v);
                check($sformatf("R3 R4 count d=%0d t=%0d", d, t), v, 32'(t - 1));
                cycles(1);
                rd(2'd3, v);
                check($sformatf("R5 pend d=%0d t=%0d", d, t), v & PEND, PEND);
                rd(2'd1, v);
                check($sformatf("R6 reload d=%0d t=%0d", d, t), v, 32'h0);
                check($sformatf("R10 irq d=%0d t=%0d", d, t), {31'h0, irq}, 32'h1);
                wr(2'd3, PEND | IE);
                rd(2'd3, v);
                check($sformatf("R8 cleared d=%0d t=%0d", d, t), v & PEND, 32'h0);
                cycles(per - 2);
                rd(2'd3, v);
                check($sformatf("R6 no early repeat d=%0d t=%0d", d, t), v & PEND, 32'h0);
                cycles(1);
                rd(2'd3, v);
                check($sformatf("R6 repeat pend d=%0d t=%0d", d, t), v & PEND, PEND);
            end
        end

        // R7 one-shot
        start(3, 4, 1'b0);
        cycles(12);
        rd(2'd3, v);
        check("R7 oneshot pend", v & PEND, PEND);
        rd(2'd2, v);
        check("R7 run bit cleared", v, 32'h3);
        wr(2'd3, PEND | IE);
        cycles(30);
        rd(2'd1, v);
        check("R7 count holds", v, 32'h4);
        rd(2'd3, v);
        check("R7 no second pend", v, IE);

        // R9 set wins over clear
        start(2, 3, 1'b1);
        cycles(5);
        wr(2'd3, PEND | IE);
        rd(2'd3, v);
        check("R9 set wins", v, PEND | IE);

        // R8 writing zero to pending has no effect
        wr(2'd3, IE);
        rd(2'd3, v);
        check("R8 zero write keeps pend", v, PEND | IE);

        // R10 enable gating
        wr(2'd3, 32'h0);
        rd(2'd3, v);
        check("R10 ie off", v, PEND);
        check("R10 irq masked", {31'h0, irq}, 32'h0);
        wr(2'd3, IE);
        check("R10 irq unmasked", {31'h0, irq}, 32'h1);

        wr(2'd2, 32'h0);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule